// File: doc/BRIEF.md
# Multicycle Instruction Sequencer with Trap Handling

This block is the control unit of a processor datapath in which one memory, one ALU and one register file are shared across several clock cycles per instruction. It walks each instruction through fetch, decode and one to three further steps, and drives every select and write-enable line of that datapath from its present state alone. Outputs are a pure function of the 4-bit state register (a Moore machine). The only inputs that steer it are the 6-bit operation code held in the datapath's instruction register and an overflow flag from the ALU.

Five instruction kinds are sequenced: word load, word store, register-to-register arithmetic, branch-if-equal and unconditional jump. Two further states act as traps. An operation code outside the supported set, or an arithmetic overflow, saves the address of the faulting instruction (the ALU forms PC minus 4), writes a one-bit cause and sends the program counter to a fixed handler address. States, in encoding order: FETCH(0), DECODE(1), ADDR(2), LDREAD(3), LDWB(4), STORE(5), EXEC(6), RDONE(7), BRANCH(8), JUMP(9), BADOP(10), OVF(11). Transitions: FETCH→DECODE; DECODE→ADDR (load/store), EXEC (arith), BRANCH, JUMP or BADOP (any other code); ADDR→LDREAD (load) or STORE (store); LDREAD→LDWB; EXEC→RDONE, or OVF when overflow is high; LDWB, STORE, RDONE, BRANCH, JUMP, BADOP and OVF→FETCH.

Top module: `mc_sequencer`

## Requirements
- R1: A synchronous reset puts the block in FETCH. FETCH drives pc_wr=1, mem_rd=1, ir_wr=1, alu_b_sel=01, pc_src=00, alu_mode=00, and 0 on every other output.
- R2: FETCH always goes to DECODE. DECODE drives alu_b_sel=11 (branch target precompute with alu_a_sel=0, alu_mode=00) and 0 on every other output.
- R3: From DECODE the operation code selects the next state: 35 (load) or 43 (store) to ADDR, 0 (arith) to EXEC, 4 (branch) to BRANCH, 2 (jump) to JUMP, and any other value to BADOP.
- R4: ADDR drives alu_a_sel=1, alu_b_sel=10, alu_mode=00. It goes to LDREAD when the code is 35 and to STORE otherwise.
- R5: LDREAD drives mem_rd=1 and addr_sel=1, then goes to LDWB. LDWB drives reg_wr=1, wb_from_mem=1, dst_sel=0, then goes to FETCH.
- R6: STORE drives mem_wr=1 and addr_sel=1, then goes to FETCH.
- R7: EXEC drives alu_a_sel=1, alu_b_sel=00, alu_mode=10. It goes to OVF when alu_ovf is high in that cycle and to RDONE otherwise.
- R8: RDONE drives reg_wr=1, dst_sel=1, wb_from_mem=0, then goes to FETCH.
- R9: BRANCH drives alu_a_sel=1, alu_mode=01, pc_wr_cond=1, pc_src=01. JUMP drives pc_wr=1, pc_src=10. Both go to FETCH.
- R10: BADOP and OVF both drive cause_wr=1, epc_wr=1, pc_wr=1, pc_src=11, alu_a_sel=0, alu_b_sel=01, alu_mode=01, and go to FETCH. cause_val is 0 in BADOP and 1 in OVF.
- R11: Counted from one FETCH to the next, the cycles per instruction are: load 5, store 4, arith 4, arith with overflow 4, branch 3, jump 3, undefined code 3.
- R12: alu_ovf has no effect outside EXEC. The operation code has no effect outside DECODE and ADDR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Operation field of the held instruction |
| alu_ovf | input | 1 | ALU arithmetic overflow flag |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write if ALU result is zero |
| addr_sel | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from memory data register (1) or ALU result (0) |
| pc_src | output | 2 | Next PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler address |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 from function field |
| alu_a_sel | output | 1 | ALU first operand: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU second operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| reg_wr | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register field: rd (1) or rt (0) |
| cause_val | output | 1 | Trap cause: 0 undefined code, 1 overflow |
| cause_wr | output | 1 | Cause register write enable |
| epc_wr | output | 1 | Exception PC register write enable |

## Verification
The overflow flag and the dispatch on the operation code can both act in the same cycle. The ALU flag may be high while the machine sits in DECODE or ADDR with a load, store or jump code, and only in EXEC may it steer the next state. The bench drives alu_ovf and the operation code at random in every cycle, including mid-instruction changes of the code. A bench model that honours the flag only in EXEC and the code only in DECODE and ADDR judges the result: the next cycle's full output vector must match the state that model predicts. Directed runs also hold overflow high through a whole load, and check that the load still takes five cycles and ends with a register write, not a trap.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDREAD = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STORE  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RDONE  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_BADOP  = 4'd10,
        ST_OVF    = 4'd11
    } seq_state_t;

    // ALU operand B selections
    localparam logic [1:0] BSEL_REGB  = 2'b00;
    localparam logic [1:0] BSEL_FOUR  = 2'b01;
    localparam logic [1:0] BSEL_IMM   = 2'b10;
    localparam logic [1:0] BSEL_IMMSH = 2'b11;

    // ALU operation classes
    localparam logic [1:0] AMODE_ADD  = 2'b00;
    localparam logic [1:0] AMODE_SUB  = 2'b01;
    localparam logic [1:0] AMODE_FUNC = 2'b10;

    // Next PC sources
    localparam logic [1:0] PCS_ALU    = 2'b00;
    localparam logic [1:0] PCS_ALUREG = 2'b01;
    localparam logic [1:0] PCS_JUMP   = 2'b10;
    localparam logic [1:0] PCS_TRAP   = 2'b11;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_from_mem;
        logic [1:0] pc_src;
        logic [1:0] alu_mode;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       reg_wr;
        logic       dst_sel;
        logic       cause_val;
        logic       cause_wr;
        logic       epc_wr;
    } seq_ctrl_t;

endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
    import mc_seq_pkg::*;
#(
    parameter int               OP_W     = 6,
    parameter logic [OP_W-1:0]  OP_ARITH = 6'd0,
    parameter logic [OP_W-1:0]  OP_JUMP  = 6'd2,
    parameter logic [OP_W-1:0]  OP_BEQ   = 6'd4,
    parameter logic [OP_W-1:0]  OP_LOAD  = 6'd35,
    parameter logic [OP_W-1:0]  OP_STORE = 6'd43
) (
    input  seq_state_t      state,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_ovf,
    output seq_state_t      nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_LOAD || opcode == OP_STORE) nxt = ST_ADDR;
                else if (opcode == OP_ARITH)                 nxt = ST_EXEC;
                else if (opcode == OP_BEQ)                   nxt = ST_BRANCH;
                else if (opcode == OP_JUMP)                  nxt = ST_JUMP;
                else                                         nxt = ST_BADOP;
            end
            ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_LDREAD : ST_STORE;
            ST_LDREAD: nxt = ST_LDWB;
            ST_EXEC:   nxt = alu_ovf ? ST_OVF : ST_RDONE;
            ST_LDWB, ST_STORE, ST_RDONE, ST_BRANCH,
            ST_JUMP, ST_BADOP, ST_OVF: nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_seq_state_reg.sv
module mc_seq_state_reg
    import mc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t nxt,
    output seq_state_t state
);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

endmodule

// File: rtl/mc_seq_decode.sv
module mc_seq_decode
    import mc_seq_pkg::*;
(
    input  seq_state_t state,
    output seq_ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.pc_wr     = 1'b1;
                ctrl.alu_b_sel = BSEL_FOUR;
                ctrl.alu_mode  = AMODE_ADD;
                ctrl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = BSEL_IMMSH;
                ctrl.alu_mode  = AMODE_ADD;
            end
            ST_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.alu_mode  = AMODE_ADD;
            end
            ST_LDREAD: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            ST_STORE: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_REGB;
                ctrl.alu_mode  = AMODE_FUNC;
            end
            ST_RDONE: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = BSEL_REGB;
                ctrl.alu_mode   = AMODE_SUB;
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = PCS_ALUREG;
            end
            ST_JUMP: begin
                ctrl.pc_wr  = 1'b1;
                ctrl.pc_src = PCS_JUMP;
            end
            ST_BADOP, ST_OVF: begin
                ctrl.cause_val = (state == ST_OVF);
                ctrl.cause_wr  = 1'b1;
                ctrl.alu_b_sel = BSEL_FOUR;
                ctrl.alu_mode  = AMODE_SUB;
                ctrl.epc_wr    = 1'b1;
                ctrl.pc_wr     = 1'b1;
                ctrl.pc_src    = PCS_TRAP;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
    import mc_seq_pkg::*;
#(
    parameter int               OP_W     = 6,
    parameter logic [OP_W-1:0]  OP_ARITH = 6'd0,
    parameter logic [OP_W-1:0]  OP_JUMP  = 6'd2,
    parameter logic [OP_W-1:0]  OP_BEQ   = 6'd4,
    parameter logic [OP_W-1:0]  OP_LOAD  = 6'd35,
    parameter logic [OP_W-1:0]  OP_STORE = 6'd43
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_ovf,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            addr_sel,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            wb_from_mem,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_mode,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic            reg_wr,
    output logic            dst_sel,
    output logic            cause_val,
    output logic            cause_wr,
    output logic            epc_wr
);

    seq_state_t state_q;
    seq_state_t state_d;
    seq_ctrl_t  ctrl;

    mc_seq_next #(
        .OP_W(OP_W), .OP_ARITH(OP_ARITH), .OP_JUMP(OP_JUMP),
        .OP_BEQ(OP_BEQ), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)
    ) u_next (
        .state   (state_q),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .nxt     (state_d)
    );

    mc_seq_state_reg u_sreg (
        .clk   (clk),
        .rst   (rst),
        .nxt   (state_d),
        .state (state_q)
    );

    mc_seq_decode u_dec (
        .state (state_q),
        .ctrl  (ctrl)
    );

    assign pc_wr       = ctrl.pc_wr;
    assign pc_wr_cond  = ctrl.pc_wr_cond;
    assign addr_sel    = ctrl.addr_sel;
    assign mem_rd      = ctrl.mem_rd;
    assign mem_wr      = ctrl.mem_wr;
    assign ir_wr       = ctrl.ir_wr;
    assign wb_from_mem = ctrl.wb_from_mem;
    assign pc_src      = ctrl.pc_src;
    assign alu_mode    = ctrl.alu_mode;
    assign alu_a_sel   = ctrl.alu_a_sel;
    assign alu_b_sel   = ctrl.alu_b_sel;
    assign reg_wr      = ctrl.reg_wr;
    assign dst_sel     = ctrl.dst_sel;
    assign cause_val   = ctrl.cause_val;
    assign cause_wr    = ctrl.cause_wr;
    assign epc_wr      = ctrl.epc_wr;

endmodule

// File: rtl/mc_seq_checker.sv
module mc_seq_checker #(
    parameter int               OP_W     = 6,
    parameter logic [OP_W-1:0]  OP_ARITH = 6'd0,
    parameter logic [OP_W-1:0]  OP_JUMP  = 6'd2,
    parameter logic [OP_W-1:0]  OP_BEQ   = 6'd4,
    parameter logic [OP_W-1:0]  OP_LOAD  = 6'd35,
    parameter logic [OP_W-1:0]  OP_STORE = 6'd43
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] opcode,
    input logic            alu_ovf,
    input logic            pc_wr,
    input logic            pc_wr_cond,
    input logic            addr_sel,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            ir_wr,
    input logic            wb_from_mem,
    input logic [1:0]      alu_mode,
    input logic [1:0]      alu_b_sel,
    input logic            reg_wr,
    input logic            cause_val,
    input logic            cause_wr
);

    logic known_op;
    assign known_op = (opcode == OP_ARITH) || (opcode == OP_JUMP) || (opcode == OP_BEQ)
                   || (opcode == OP_LOAD)  || (opcode == OP_STORE);

    // R1: reset lands in the fetch step
    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (ir_wr && mem_rd && pc_wr));

    // R2: fetch is followed by decode
    p_fetch_decode_r2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (alu_b_sel == 2'b11 && !ir_wr));

    // R3: unsupported code in decode leads to the undefined-code trap
    p_badop_r3: assert property (@(posedge clk) disable iff (rst)
        (alu_b_sel == 2'b11 && !known_op) |=> (cause_wr && !cause_val));

    // R5: load read is followed by write-back from memory
    p_load_wb_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel) |=> (reg_wr && wb_from_mem));

    // R6: store returns to fetch
    p_store_ret_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

    // R7: overflow during execute raises the overflow trap
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (alu_mode == 2'b10 && alu_ovf) |=> (cause_wr && cause_val));

    // R9: branch returns to fetch
    p_branch_ret_r9: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |=> ir_wr);

    // R10: trap returns to fetch
    p_trap_ret_r10: assert property (@(posedge clk) disable iff (rst)
        cause_wr |=> ir_wr);

endmodule

bind mc_sequencer mc_seq_checker #(
    .OP_W(OP_W), .OP_ARITH(OP_ARITH), .OP_JUMP(OP_JUMP),
    .OP_BEQ(OP_BEQ), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .opcode      (opcode),
    .alu_ovf     (alu_ovf),
    .pc_wr       (pc_wr),
    .pc_wr_cond  (pc_wr_cond),
    .addr_sel    (addr_sel),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .ir_wr       (ir_wr),
    .wb_from_mem (wb_from_mem),
    .alu_mode    (alu_mode),
    .alu_b_sel   (alu_b_sel),
    .reg_wr      (reg_wr),
    .cause_val   (cause_val),
    .cause_wr    (cause_wr)
);

// File: tb/mc_sequencer_test.sv
module mc_sequencer_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       alu_ovf = 1'b0;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_from_mem;
    logic [1:0] pc_src, alu_mode, alu_b_sel;
    logic       alu_a_sel, reg_wr, dst_sel, cause_val, cause_wr, epc_wr;

    int n_checks = 0;
    int n_bad    = 0;
    int st       = 0;   // bench model state, 0..11

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_sequencer uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .wb_from_mem(wb_from_mem), .pc_src(pc_src), .alu_mode(alu_mode),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .reg_wr(reg_wr),
        .dst_sel(dst_sel), .cause_val(cause_val), .cause_wr(cause_wr),
        .epc_wr(epc_wr)
    );

    // order: pc_wr pc_wr_cond addr_sel mem_rd mem_wr ir_wr wb_from_mem pc_src(2)
    //        alu_mode(2) alu_a_sel alu_b_sel(2) reg_wr dst_sel cause_val cause_wr epc_wr
    function automatic logic [18:0] exp_out(input int s);
        logic pw, pwc, as, mr, mw, iw, wm, aa, rw, ds, cv, cw, ew;
        logic [1:0] ps, am, bs;
        {pw, pwc, as, mr, mw, iw, wm, aa, rw, ds, cv, cw, ew} = '0;
        ps = 2'b00; am = 2'b00; bs = 2'b00;
        case (s)
            0:  begin pw = 1; mr = 1; iw = 1; bs = 2'b01; end
            1:  bs = 2'b11;
            2:  begin aa = 1; bs = 2'b10; end
            3:  begin mr = 1; as = 1; end
            4:  begin rw = 1; wm = 1; end
            5:  begin mw = 1; as = 1; end
            6:  begin aa = 1; am = 2'b10; end
            7:  begin rw = 1; ds = 1; end
            8:  begin aa = 1; am = 2'b01; pwc = 1; ps = 2'b01; end
            9:  begin pw = 1; ps = 2'b10; end
            10, 11: begin cv = (s == 11); cw = 1; ew = 1; pw = 1; ps = 2'b11;
                          bs = 2'b01; am = 2'b01; end
            default: ;
        endcase
        return {pw, pwc, as, mr, mw, iw, wm, ps, am, aa, bs, rw, ds, cv, cw, ew};
    endfunction

    function automatic int model_next(input int s, input logic [5:0] op, input logic ov);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'd35 || op == 6'd43) return 2;
                if (op == 6'd0)  return 6;
                if (op == 6'd4)  return 8;
                if (op == 6'd2)  return 9;
                return 10;
            end
            2: return (op == 6'd35) ? 3 : 5;
            3: return 4;
            6: return ov ? 11 : 7;
            default: return 0;
        endcase
    endfunction

    function automatic string state_tag(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            8, 9: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [18:0] dut_out();
        return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_from_mem,
                pc_src, alu_mode, alu_a_sel, alu_b_sel, reg_wr, dst_sel,
                cause_val, cause_wr, epc_wr};
    endfunction

    task automatic check_vec(input string tag, input logic [18:0] act, input logic [18:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs act=%b exp=%b (model state %0d)", tag, act, exp, st);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Called just after a falling edge: check, drive, advance one cycle.
    task automatic step(input string tag, input logic [5:0] op, input logic ov, input logic rs);
        int nx;
        check_vec(tag, dut_out(), exp_out(st));
        opcode  = op;
        alu_ovf = ov;
        rst     = rs;
        nx = rs ? 0 : model_next(st, op, ov);
        @(posedge clk);
        st = nx;
        @(negedge clk);
        #1;
    endtask

    // R11: count cycles from one fetch to the next, seen at the ports
    task automatic run_instr(input string name, input logic [5:0] op, input logic ov, input int len);
        int n = 0;
        step(state_tag(st), op, ov, 1'b0);
        n++;
        while (ir_wr !== 1'b1 && n < 12) begin
            step((st == 2 || st == 6 || ov) ? "R12" : state_tag(st), op, ov, 1'b0);
            n++;
        end
        check_int({"R11 ", name}, n, len);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        alu_ovf = 1'b1;
        opcode = 6'd63;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        st = 0;
        check_vec("R1 reset", dut_out(), exp_out(0));
        rst = 1'b0;
        alu_ovf = 1'b0;

        // directed instruction lengths
        run_instr("load",        6'd35, 1'b0, 5);
        run_instr("store",       6'd43, 1'b0, 4);
        run_instr("arith",       6'd0,  1'b0, 4);
        run_instr("arith ovf",   6'd0,  1'b1, 4);
        run_instr("branch",      6'd4,  1'b0, 3);
        run_instr("jump",        6'd2,  1'b0, 3);
        run_instr("undef",       6'd63, 1'b0, 3);
        run_instr("undef one",   6'd1,  1'b0, 3);
        // R12: overflow held high through a load and a jump changes nothing
        run_instr("load ovf",    6'd35, 1'b1, 5);
        run_instr("jump ovf",    6'd2,  1'b1, 3);
        run_instr("store ovf",   6'd43, 1'b1, 4);

        // R3 / R12: random codes and overflow every cycle, occasional reset
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] op;
            logic ov, rs;
            int pick;
            string tag;
            pick = int'($urandom % 8);
            case (pick)
                0: op = 6'd0;
                1: op = 6'd35;
                2: op = 6'd43;
                3: op = 6'd4;
                4: op = 6'd2;
                default: op = 6'($urandom % 64);
            endcase
            ov = ($urandom % 3) == 0;
            rs = ($urandom % 97) == 0;
            tag = state_tag(st);
            step(tag, op, ov, rs);
            // after the edge: label the landing check by the rule that chose it
            if (!rs && st != 0) begin
                n_checks++;
                if (dut_out() !== exp_out(st)) begin
                    n_bad++;
                    $display("FAIL %s: next-state outputs act=%b exp=%b",
                             (st == 10 || (st >= 2 && st <= 9 && st != 3 && st != 4 && st != 7 && st != 5)) ? "R3" :
                             (st == 11 || st == 7) ? "R7" : "R12",
                             dut_out(), exp_out(st));
                end
            end
        end
        rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule